// File: doc/BRIEF.md
# Serially Programmed Two-Clock Output Selector Bank

The block routes one of two input clocks to each of ten outputs. A three-wire serial port (serial clock, serial data, load strobe) programs a 10-bit selection word. Each rising edge of the serial clock pushes one data bit into a shift register. The rising edge of the load strobe copies the whole shift register into a holding register. Each held bit controls one 2:1 selector. A held 1 passes clock input 0 to that output, and a held 0 passes clock input 1.

The most significant shift stage drives a serial output. Several blocks can therefore share the serial clock and load strobe, with each block's serial output feeding the next block's serial input. A long word is shifted through the whole chain and then loaded into every block at once.

The serial pins are oversampled by the synchronous system clock, and their rising edges are detected inside the block. The selectors themselves are plain combinational logic, so a change on either input clock reaches the outputs with no register stage.

Top module: `clksel_xpoint`

## Requirements
- R1: A synchronous active-high reset clears the shift register and the holding register to all zeros. After reset the serial output is 0 and every output routes clock input 1.
- R2: On each detected rising edge of the serial clock, the shift register moves up one place and the serial data bit enters bit 0. The first bit sent reaches bit 9 after ten edges.
- R3: A serial clock that stays high or stays low does not shift. A single rising edge shifts exactly once, however long the line then stays high.
- R4: The holding register changes only on a rising edge of the load strobe. Shifting while the strobe is low, or held high, leaves the outputs unchanged.
- R5: Output i carries clock input 0 when held bit i is 1 and clock input 1 when it is 0. This path is combinational, so a change on an input clock reaches the outputs without any clock edge.
- R6: The serial output equals bit 9 of the shift register. A bit therefore leaves the block on the eleventh rising edge after it entered, which lets two blocks chained serial-output-to-serial-input hold a 20-bit stream. The bits sent first end up in the far block.
- R7: When a load edge and a serial clock edge fall in the same system cycle, the holding register takes the shift register contents from before that shift.
- R8: Bit position maps one to one onto output index. The bit sent first (bit 9, MSB) controls output 9, and the bit sent last controls output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock; rising edges shift |
| ser_din | input | 1 | Serial data bit |
| ser_load | input | 1 | Load strobe; rising edge copies the shift register into the holding register |
| clk_in0 | input | 1 | Clock input 0, chosen by a held 1 |
| clk_in1 | input | 1 | Clock input 1, chosen by a held 0 |
| ser_dout | output | 1 | Cascade output, bit 9 of the shift register |
| clk_out | output | 10 | Selected clock per output |

## Verification
The hardest case to reach is a load edge that lands in the same sampling cycle as a serial clock edge. In that case the held word must be the one from before the shift (R7). The bench reaches it by raising both lines on the same falling system-clock edge. It then loads again to show that the shifted word was also kept.

Cascade ordering needs a second instance whose data input is the first instance's serial output. Twenty pulses then have to separate into two words, and the words are checked at both blocks' outputs. Selector polarity is exposed by driving the two input clocks to opposite static levels in both orders, which turns each output into a direct readout of its held bit.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int unsigned XP_WIDTH = 10;

    typedef logic [XP_WIDTH-1:0] xp_word_t;

    function automatic logic route_bit(input logic sel, input logic c0, input logic c1);
        return sel ? c0 : c1;
    endfunction

endpackage

// File: rtl/clksel_edge.sv
module clksel_edge #(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic line,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RESET_LEVEL;
        else     prev_q <= line;
    end

    assign rise = line & ~prev_q;

    p_single_rise_r3: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/clksel_shifter.sv
module clksel_shifter #(
    parameter int unsigned N = clksel_pkg::XP_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [N-1:0] shift_q,
    output logic         dout
);
    localparam int unsigned TOP = N - 1;

    always_ff @(posedge clk) begin
        if (rst)           shift_q <= '0;
        else if (shift_en) shift_q <= {shift_q[TOP-1:0], din};
    end

    assign dout = shift_q[TOP];

    p_no_shift_r3: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(shift_q));
    p_cascade_r6: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> dout == $past(shift_q[TOP-1]));
endmodule

// File: rtl/clksel_holdreg.sv
module clksel_holdreg #(
    parameter int unsigned N = clksel_pkg::XP_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [N-1:0] shift_word,
    output logic [N-1:0] hold_q
);
    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (load_en) hold_q <= shift_word;
    end

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(hold_q));
    p_load_preshift_r7: assert property (@(posedge clk) disable iff (rst)
        load_en |=> hold_q == $past(shift_word));
endmodule

// File: rtl/clksel_mux.sv
module clksel_mux #(
    parameter int unsigned N = clksel_pkg::XP_WIDTH
) (
    input  logic [N-1:0] sel,
    input  logic         c0,
    input  logic         c1,
    output logic [N-1:0] out
);
    for (genvar gi = 0; gi < N; gi++) begin : g_sel
        assign out[gi] = clksel_pkg::route_bit(sel[gi], c0, c1);
    end
endmodule

// File: rtl/clksel_xpoint.sv
module clksel_xpoint #(
    parameter int unsigned N = clksel_pkg::XP_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_clk,
    input  logic         ser_din,
    input  logic         ser_load,
    input  logic         clk_in0,
    input  logic         clk_in1,
    output logic         ser_dout,
    output logic [N-1:0] clk_out
);
    logic         sclk_rise;
    logic         load_rise;
    logic [N-1:0] shift_w;
    logic [N-1:0] hold_w;

    clksel_edge #(.RESET_LEVEL(1'b1)) u_sclk_edge (
        .clk(clk), .rst(rst), .line(ser_clk), .rise(sclk_rise));

    clksel_edge #(.RESET_LEVEL(1'b1)) u_load_edge (
        .clk(clk), .rst(rst), .line(ser_load), .rise(load_rise));

    clksel_shifter #(.N(N)) u_shift (
        .clk(clk), .rst(rst), .shift_en(sclk_rise), .din(ser_din),
        .shift_q(shift_w), .dout(ser_dout));

    clksel_holdreg #(.N(N)) u_hold (
        .clk(clk), .rst(rst), .load_en(load_rise), .shift_word(shift_w),
        .hold_q(hold_w));

    clksel_mux #(.N(N)) u_mux (
        .sel(hold_w), .c0(clk_in0), .c1(clk_in1), .out(clk_out));

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hold_w == '0 && ser_dout == 1'b0));
    p_equal_inputs_r5: assert property (@(posedge clk) disable iff (rst)
        (clk_in0 == clk_in1) |-> clk_out == {N{clk_in0}});
endmodule

// File: tb/clksel_xpoint_tb.sv
module clksel_xpoint_tb;
    localparam int N = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst;
    logic drv_en, sclk_drv, din_drv, load_drv;
    logic c0, c1;
    // pull-down model: a released pin reads low
    wire  ser_clk_w  = drv_en ? sclk_drv : 1'b0;
    wire  ser_din_w  = drv_en ? din_drv  : 1'b0;
    wire  ser_load_w = drv_en ? load_drv : 1'b0;

    logic         dout_a, dout_b;
    logic [N-1:0] out_a, out_b;

    clksel_xpoint #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk_w), .ser_din(ser_din_w),
        .ser_load(ser_load_w), .clk_in0(c0), .clk_in1(c1),
        .ser_dout(dout_a), .clk_out(out_a));

    clksel_xpoint #(.N(N)) u_dut_b (
        .clk(clk), .rst(rst), .ser_clk(ser_clk_w), .ser_din(dout_a),
        .ser_load(ser_load_w), .clk_in0(c0), .clk_in1(c1),
        .ser_dout(dout_b), .clk_out(out_b));

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [N-1:0] m_sa, m_sb, m_ha, m_hb;

    function automatic logic [N-1:0] exp_out(input logic [N-1:0] held, input logic a0, input logic a1);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = held[i] ? a0 : a1;
        return r;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sa = '0; m_sb = '0; m_ha = '0; m_hb = '0;
    endtask

    task automatic sclk_pulse(input logic d, input bit chk);
        din_drv = d;
        step(1);
        sclk_drv = 1'b1;
        step(2);
        m_sb = {m_sb[N-2:0], m_sa[N-1]};
        m_sa = {m_sa[N-2:0], d};
        if (chk) check_eq("R6 cascade bit", {31'd0, dout_a}, {31'd0, m_sa[N-1]});
        sclk_drv = 1'b0;
        step(1);
    endtask

    task automatic send_word(input logic [N-1:0] w);
        for (int i = N - 1; i >= 0; i--) sclk_pulse(w[i], 1'b1);
    endtask

    task automatic load_pulse();
        load_drv = 1'b1;
        step(2);
        m_ha = m_sa; m_hb = m_sb;
        load_drv = 1'b0;
        step(1);
    endtask

    task automatic check_routes(input string req);
        c0 = 1'b1; c1 = 1'b0; #1;
        check_eq(req, {22'd0, out_a}, {22'd0, exp_out(m_ha, 1'b1, 1'b0)});
        check_eq(req, {22'd0, out_b}, {22'd0, exp_out(m_hb, 1'b1, 1'b0)});
        c0 = 1'b0; c1 = 1'b1; #1;
        check_eq(req, {22'd0, out_a}, {22'd0, exp_out(m_ha, 1'b0, 1'b1)});
        check_eq(req, {22'd0, out_b}, {22'd0, exp_out(m_hb, 1'b0, 1'b1)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; drv_en = 1'b0; sclk_drv = 1'b0; din_drv = 1'b0; load_drv = 1'b0;
        c0 = 1'b1; c1 = 1'b0;
        model_reset();
        step(3);
        rst = 1'b0;
        step(4);
        // R1: reset state with pins released (pulled low)
        check_eq("R1 dout after reset", {31'd0, dout_a}, 32'd0);
        check_routes("R1 outputs route clock input 1");
        drv_en = 1'b1;

        // R2/R8: first bit sent lands in MSB and drives output 9
        send_word(10'h200);
        check_eq("R2 MSB visible on dout", {31'd0, dout_a}, 32'd1);
        load_pulse();
        check_routes("R8 walking one to output 9");
        send_word(10'h2B5);
        load_pulse();
        check_routes("R2 word 2B5");

        // R3: serial clock held high shifts only once
        din_drv = 1'b1;
        step(1);
        sclk_drv = 1'b1;
        step(8);
        m_sb = {m_sb[N-2:0], m_sa[N-1]};
        m_sa = {m_sa[N-2:0], 1'b1};
        sclk_drv = 1'b0;
        step(5);
        check_eq("R3 held-high single shift", {31'd0, dout_a}, {31'd0, m_sa[N-1]});
        load_pulse();
        check_routes("R3 held-high single shift");

        // R4: shifting without a load edge leaves outputs alone
        send_word(10'h0F3);
        check_routes("R4 no load, outputs unchanged");
        load_drv = 1'b1;
        step(2);
        m_ha = m_sa; m_hb = m_sb;
        send_word(10'h155);
        check_routes("R4 load held high, outputs unchanged");
        load_drv = 1'b0;
        step(2);
        check_routes("R4 load falling edge ignored");
        load_pulse();
        check_routes("R4 load rise captures");

        // R7: load edge and serial edge in the same cycle
        send_word(10'h3C1);
        din_drv = 1'b0;
        step(1);
        sclk_drv = 1'b1; load_drv = 1'b1;
        step(2);
        m_ha = m_sa; m_hb = m_sb;
        m_sb = {m_sb[N-2:0], m_sa[N-1]};
        m_sa = {m_sa[N-2:0], 1'b0};
        sclk_drv = 1'b0; load_drv = 1'b0;
        step(2);
        check_routes("R7 simultaneous edges take pre-shift word");
        load_pulse();
        check_routes("R7 shifted word retained");

        // R6: two-block chain, first word goes to the far block
        send_word(10'h2A7);
        send_word(10'h158);
        load_pulse();
        check_eq("R6 far block word", {22'd0, m_hb}, 32'h2A7);
        check_routes("R6 chained words");

        // R5: selection is combinational, no clock edge needed
        c0 = 1'b1; c1 = 1'b1; #1;
        check_eq("R5 both inputs high", {22'd0, out_a}, 32'h3FF);
        c0 = 1'b0; c1 = 1'b0; #1;
        check_eq("R5 both inputs low", {22'd0, out_a}, 32'h000);

        // random words with random load decisions
        for (int k = 0; k < 24; k++) begin
            logic [N-1:0] w;
            w = N'($urandom);
            send_word(w);
            if ($urandom_range(0, 3) != 0) load_pulse();
            check_routes("R2 R5 random word");
        end

        // R1: reset mid-run clears everything
        send_word(10'h3FF);
        load_pulse();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        model_reset();
        step(2);
        check_eq("R1 dout cleared", {31'd0, dout_a}, 32'd0);
        check_routes("R1 mid-run reset");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule